// File: doc/BRIEF.md
# Block-Cipher Mode Sequencer

This block sits between a stream of 128-bit data blocks and a 128-bit block-cipher engine. It turns the bare engine into one of several chaining modes. For each incoming block it prepares the engine input, issues it over a valid/ready request, waits for the engine result, and then either emits a result block or folds the result back into its single IV register. The modes are plain electronic codebook, CBC-MAC, counter, output feedback, and a two-pass CCM flow. In the CCM flow the first pass authenticates and the second pass encrypts.

Software first loads the key, key length, IV and mode through a one-cycle configuration strobe while the block is idle, and then pulses `start`. Upstream presents blocks with a last-block flag. The CBC-MAC tag is held on a separate output and stays valid until the next start.

In CCM, the block after the last authenticated block is not processed. It becomes the initial counter for the encryption pass. The engine is modelled outside this block, and data formatting is left to software.

Top module: `cipher_mode_seq`

## Requirements
- R1: After reset, `busy`, `done`, `tag_valid`, `out_valid`, `in_ready` and `eng_valid` are all low.
- R2: Mode code 0 (codebook; codes 5 to 7 behave the same) sends each input block to the engine unchanged and emits the engine result as `out_data`.
- R3: Mode code 1 (CBC-MAC) sends `block XOR chain` to the engine, with the chain starting at the loaded IV and replaced by each engine result. It emits no data block. The final engine result appears on `tag_out` with `tag_valid` high, and `tag_out` stays stable until the next start.
- R4: Mode code 2 (counter) sends the IV register to the engine and emits `block XOR result`. After each accepted engine request, bits [31:0] of the register increment modulo 2^32 and bits [127:32] stay unchanged.
- R5: Mode code 3 (output feedback) sends the IV register to the engine, emits `block XOR result`, and replaces the IV register with the engine result.
- R6: Mode code 4 (CCM) first runs CBC-MAC up to the block flagged last, and raises `tag_valid` while `busy` is still high. The next input block loads the IV register as the counter and is neither processed nor emitted. Counter mode then runs up to the next block flagged last.
- R7: Key-length code 0 keeps only `cfg_key[127:0]`, code 1 keeps `cfg_key[191:0]`, and codes 2 and 3 keep all 256 bits. Unused bits read as zero on `eng_key`, and `eng_klen` carries the code.
- R8: `eng_valid` rises only after a whole input block has been captured and `in_ready` has dropped. It stays high, with `eng_block` stable, until `eng_ready`. `in_ready` is high only while busy and waiting for a block.
- R9: `start` while idle sets `busy` and clears `done` and `tag_valid`. On completion `busy` falls and `done` rises. The two are never high together.
- R10: A configuration strobe while `busy` is high has no effect on the running operation.
- R11: Each emitted data block is a one-cycle `out_valid` pulse, and blocks come out in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration strobe, taken only when idle |
| cfg_mode | input | 3 | Mode code |
| cfg_klen | input | 2 | Key-length code |
| cfg_key | input | 256 | Key |
| cfg_iv | input | 128 | IV, initial chain or counter |
| start | input | 1 | Begin an operation (idle only) |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block is waiting for an input block |
| in_data | input | 128 | Input block |
| in_last | input | 1 | Marks the last block of a pass |
| eng_valid | output | 1 | Engine request |
| eng_ready | input | 1 | Engine accepts the request |
| eng_key | output | 256 | Length-masked key |
| eng_klen | output | 2 | Key-length code |
| eng_block | output | 128 | Engine input block |
| eng_out_valid | input | 1 | Engine result pulse |
| eng_out | input | 128 | Engine result |
| out_valid | output | 1 | Result block pulse |
| out_data | output | 128 | Result block |
| tag_valid | output | 1 | Tag available |
| tag_out | output | 128 | CBC-MAC tag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished |

## Verification
The embedded assertions check the following on every cycle:
- the engine request holds, with a stable block, until it is accepted;
- `in_ready` appears only while busy;
- `busy` and `done` are never high together;
- the counter step preserves the upper 96 bits and wraps the low word;
- a configuration strobe while busy leaves the configuration untouched;
- `out_valid` is a single-cycle pulse;
- no data block follows a CBC-MAC step;
- the tag stays held until the next start.

Only the bench's scenarios can show that the data is correct. That covers each mode's chaining values, counter wrap across 2^32, key masking per length code, the CCM counter hand-over between passes, and the exact number and order of emitted blocks.

// File: rtl/cms_pkg.sv
// Shared types for the cipher mode sequencer.
// Assumes: mode codes are decoded by software exactly as listed here.
package cms_pkg;
    typedef enum logic [2:0] {
        MD_ECB    = 3'd0,
        MD_CBCMAC = 3'd1,
        MD_CTR    = 3'd2,
        MD_OFB    = 3'd3,
        MD_CCM    = 3'd4
    } md_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ARR,
        ST_ISSUE,
        ST_WAIT,
        ST_POST
    } st_e;
endpackage

// File: rtl/cms_ctrl.sv
// Sequencing FSM: fetch a block, arrange the engine input, issue it, wait for
// the result, post-process it. Tracks the CCM pass and the counter-seed step.
// Assumes: the mode input is stable while busy (guarded at the top level).
module cms_ctrl
    import cms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  md_e  mode,
    input  logic in_valid,
    input  logic in_last,
    input  logic eng_ready,
    input  logic eng_out_valid,
    output logic in_ready,
    output logic seed_take,
    output logic blk_take,
    output logic arr_en,
    output logic eng_valid,
    output logic issue_fire,
    output logic raw_take,
    output logic post_en,
    output md_e  eff_mode,
    output logic tag_set,
    output logic busy,
    output logic done,
    output logic tag_valid
);
    st_e  st;
    logic pass2;
    logic seed;
    logic last_q;

    // Mode in force for the current step; CCM maps to its current pass.
    always_comb begin
        case (mode)
            MD_CCM:  eff_mode = pass2 ? MD_CTR : MD_CBCMAC;
            default: eff_mode = mode;
        endcase
    end

    // State-derived strobes for the datapath.
    assign in_ready   = (st == ST_FETCH);
    assign seed_take  = in_ready && in_valid && seed;
    assign blk_take   = in_ready && in_valid && !seed;
    assign arr_en     = (st == ST_ARR);
    assign eng_valid  = (st == ST_ISSUE);
    assign issue_fire = eng_valid && eng_ready;
    assign raw_take   = (st == ST_WAIT) && eng_out_valid;
    assign post_en    = (st == ST_POST);
    assign tag_set    = post_en && last_q && (eff_mode == MD_CBCMAC);

    // State, pass tracking and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pass2     <= 1'b0;
            seed      <= 1'b0;
            last_q    <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            tag_valid <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st        <= ST_FETCH;
                        busy      <= 1'b1;
                        done      <= 1'b0;
                        tag_valid <= 1'b0;
                        pass2     <= 1'b0;
                        seed      <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (in_valid) begin
                        if (seed) begin
                            seed <= 1'b0;
                        end else begin
                            last_q <= in_last;
                            st     <= ST_ARR;
                        end
                    end
                end
                ST_ARR:   st <= ST_ISSUE;
                ST_ISSUE: if (eng_ready) st <= ST_WAIT;
                ST_WAIT:  if (eng_out_valid) st <= ST_POST;
                ST_POST: begin
                    if (last_q) begin
                        if (tag_set) tag_valid <= 1'b1;
                        if (mode == MD_CCM && !pass2) begin
                            pass2 <= 1'b1;
                            seed  <= 1'b1;
                            st    <= ST_FETCH;
                        end else begin
                            busy <= 1'b0;
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end
                    end else begin
                        st <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !tag_valid));
    p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> eng_valid);
    p_req_after_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> !in_ready);
endmodule

// File: rtl/cms_ivreg.sv
// Single IV register: holds the loaded IV, the CBC/OFB chaining value, and
// serves as the counter in counter mode (low CTR_W bits step, rest held).
// Assumes: at most one update source matters; load wins over chain over step.
module cms_ivreg #(
    parameter int BLK_W = 128,
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [BLK_W-1:0] load_val,
    input  logic             chain_en,
    input  logic [BLK_W-1:0] chain_val,
    input  logic             inc_en,
    output logic [BLK_W-1:0] iv
);
    // Prioritised update of the IV / chain / counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv <= '0;
        end else if (load_en) begin
            iv <= load_val;
        end else if (chain_en) begin
            iv <= chain_val;
        end else if (inc_en) begin
            iv[CTR_W-1:0] <= iv[CTR_W-1:0] + CTR_W'(1);
        end
    end

    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !load_en && !chain_en) |=>
        (iv[BLK_W-1:CTR_W] == $past(iv[BLK_W-1:CTR_W]))
        && (iv[CTR_W-1:0] == $past(iv[CTR_W-1:0]) + CTR_W'(1)));
endmodule

// File: rtl/cms_keymask.sv
// Zeroes key words beyond the selected key length, one word per generate slot.
// Assumes: KEY_W is a multiple of WORD_W and of 4*WORD_W/... lengths are
// KEY_W/2, 3*KEY_W/4 and KEY_W for codes 0, 1 and 2/3.
module cms_keymask #(
    parameter int KEY_W  = 256,
    parameter int WORD_W = 64
) (
    input  logic [KEY_W-1:0] key,
    input  logic [1:0]       klen,
    output logic [KEY_W-1:0] key_eff
);
    localparam int NW    = KEY_W / WORD_W;
    localparam int LIM_W = $clog2(KEY_W) + 2;

    logic [LIM_W-1:0] lim;

    // Number of key bits in use for the length code.
    always_comb begin
        case (klen)
            2'd0:    lim = LIM_W'(KEY_W / 2);
            2'd1:    lim = LIM_W'((KEY_W * 3) / 4);
            default: lim = LIM_W'(KEY_W);
        endcase
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        assign key_eff[w*WORD_W +: WORD_W] =
            (LIM_W'((w + 1) * WORD_W) <= lim) ? key[w*WORD_W +: WORD_W] : '0;
    end
endmodule

// File: rtl/cms_xform.sv
// Per-mode input arrangement and output modification (pure logic; each result
// is registered by the caller, so each takes a single cycle).
// Assumes: eff_mode never carries the CCM code.
module cms_xform
    import cms_pkg::*;
#(
    parameter int BLK_W = 128
) (
    input  md_e              eff_mode,
    input  logic [BLK_W-1:0] din,
    input  logic [BLK_W-1:0] iv,
    input  logic [BLK_W-1:0] raw,
    output logic [BLK_W-1:0] arr_blk,
    output logic [BLK_W-1:0] post_blk
);
    // Engine input: XOR chaining ahead of the engine for CBC-MAC only.
    always_comb begin
        case (eff_mode)
            MD_CBCMAC:      arr_blk = din ^ iv;
            MD_CTR, MD_OFB: arr_blk = iv;
            default:        arr_blk = din;
        endcase
    end

    // Engine output: keystream XOR behind the engine for CTR and OFB.
    always_comb begin
        case (eff_mode)
            MD_CTR, MD_OFB: post_blk = raw ^ din;
            default:        post_blk = raw;
        endcase
    end
endmodule

// File: rtl/cipher_mode_seq.sv
// Top of the cipher mode sequencer: configuration registers, block staging
// registers, and the glue between FSM, IV register, key mask and transforms.
// Assumes: the engine holds its result for one eng_out_valid pulse and takes
// one request at a time.
module cipher_mode_seq
    import cms_pkg::*;
#(
    parameter int BLK_W = 128,
    parameter int KEY_W = 256,
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [2:0]       cfg_mode,
    input  logic [1:0]       cfg_klen,
    input  logic [KEY_W-1:0] cfg_key,
    input  logic [BLK_W-1:0] cfg_iv,
    input  logic             start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_data,
    input  logic             in_last,
    output logic             eng_valid,
    input  logic             eng_ready,
    output logic [KEY_W-1:0] eng_key,
    output logic [1:0]       eng_klen,
    output logic [BLK_W-1:0] eng_block,
    input  logic             eng_out_valid,
    input  logic [BLK_W-1:0] eng_out,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_data,
    output logic             tag_valid,
    output logic [BLK_W-1:0] tag_out,
    output logic             busy,
    output logic             done
);
    localparam int WORD_W = KEY_W / 4;

    logic [KEY_W-1:0] key_q;
    logic [1:0]       klen_q;
    md_e              mode_q;
    logic [BLK_W-1:0] din_q, blk_q, raw_q, out_q, tag_q, iv;
    logic [BLK_W-1:0] arr_blk, post_blk;
    logic             ov_q;
    logic             cfg_ok;
    logic             seed_take, blk_take, arr_en, issue_fire, raw_take;
    logic             post_en, tag_set;
    md_e              eff_mode;

    assign cfg_ok = cfg_load && !busy;

    // Configuration capture, idle only; unknown mode codes fall back to ECB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            klen_q <= 2'd0;
            mode_q <= MD_ECB;
        end else if (cfg_ok) begin
            key_q  <= cfg_key;
            klen_q <= cfg_klen;
            mode_q <= (cfg_mode > 3'd4) ? MD_ECB : md_e'(cfg_mode);
        end
    end

    cms_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode         (mode_q),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .eng_ready    (eng_ready),
        .eng_out_valid(eng_out_valid),
        .in_ready     (in_ready),
        .seed_take    (seed_take),
        .blk_take     (blk_take),
        .arr_en       (arr_en),
        .eng_valid    (eng_valid),
        .issue_fire   (issue_fire),
        .raw_take     (raw_take),
        .post_en      (post_en),
        .eff_mode     (eff_mode),
        .tag_set      (tag_set),
        .busy         (busy),
        .done         (done),
        .tag_valid    (tag_valid)
    );

    cms_ivreg #(.BLK_W(BLK_W), .CTR_W(CTR_W)) u_iv (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cfg_ok || seed_take),
        .load_val (cfg_ok ? cfg_iv : in_data),
        .chain_en (post_en && (eff_mode == MD_CBCMAC || eff_mode == MD_OFB)),
        .chain_val(raw_q),
        .inc_en   (issue_fire && (eff_mode == MD_CTR)),
        .iv       (iv)
    );

    cms_keymask #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_kmask (
        .key    (key_q),
        .klen   (klen_q),
        .key_eff(eng_key)
    );

    cms_xform #(.BLK_W(BLK_W)) u_xf (
        .eff_mode(eff_mode),
        .din     (din_q),
        .iv      (iv),
        .raw     (raw_q),
        .arr_blk (arr_blk),
        .post_blk(post_blk)
    );

    // Block staging: input capture, arranged engine input, raw engine result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
            blk_q <= '0;
            raw_q <= '0;
        end else begin
            if (blk_take) din_q <= in_data;
            if (arr_en)   blk_q <= arr_blk;
            if (raw_take) raw_q <= eng_out;
        end
    end

    // Result emission and tag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q  <= 1'b0;
            out_q <= '0;
            tag_q <= '0;
        end else begin
            ov_q <= post_en && (eff_mode != MD_CBCMAC);
            if (post_en && eff_mode != MD_CBCMAC) out_q <= post_blk;
            if (tag_set) tag_q <= raw_q;
        end
    end

    assign eng_block = blk_q;
    assign eng_klen  = klen_q;
    assign out_valid = ov_q;
    assign out_data  = out_q;
    assign tag_out   = tag_q;

    p_block_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_ready) |=> $stable(eng_block));
    p_no_data_cbc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && eff_mode == MD_CBCMAC) |=> !out_valid);
    p_tag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !start) |=> (tag_valid && $stable(tag_out)));
    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && busy) |=> ($stable(key_q) && $stable(klen_q) && $stable(mode_q)));
    p_out_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: tb/cipher_mode_seq_tb.sv
// Scoreboard bench: run tasks push expected blocks, a monitor pops and
// compares on each out_valid. The engine is a keyed rotate/XOR stand-in
// with a fixed latency and a ready line that toggles.
module cipher_mode_seq_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_load, start, in_valid, in_last;
    logic [2:0]   cfg_mode;
    logic [1:0]   cfg_klen;
    logic [255:0] cfg_key;
    logic [127:0] cfg_iv, in_data;
    logic         in_ready, eng_valid, eng_ready, eng_out_valid;
    logic [255:0] eng_key;
    logic [1:0]   eng_klen;
    logic [127:0] eng_block, eng_out, out_data, tag_out;
    logic         out_valid, tag_valid, busy, done;

    int           total = 0;
    int           bad = 0;
    int           got = 0;
    int           cyc = 0;
    string        cur_req = "R2";
    logic [127:0] exp_q[$];

    always #2.5 clk = ~clk;

    cipher_mode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_klen(cfg_klen), .cfg_key(cfg_key), .cfg_iv(cfg_iv), .start(start),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .eng_valid(eng_valid), .eng_ready(eng_ready),
        .eng_key(eng_key), .eng_klen(eng_klen), .eng_block(eng_block),
        .eng_out_valid(eng_out_valid), .eng_out(eng_out), .out_valid(out_valid),
        .out_data(out_data), .tag_valid(tag_valid), .tag_out(tag_out),
        .busy(busy), .done(done)
    );

    function automatic logic [255:0] kmask(input logic [255:0] k, input logic [1:0] kl);
        if (kl == 2'd0) return {128'b0, k[127:0]};
        if (kl == 2'd1) return {64'b0, k[191:0]};
        return k;
    endfunction

    function automatic logic [127:0] ef(input logic [255:0] k, input logic [1:0] kl,
                                        input logic [127:0] b);
        return {b[118:0], b[127:119]} ^ k[127:0] ^ k[255:128] ^ {126'b0, kl};
    endfunction

    function automatic logic [127:0] mkblk(input logic [127:0] s, input int i);
        logic [31:0] w;
        w = (32'(i) * 32'h9E3779B9) ^ 32'h13579BDF;
        return s ^ {w, ~w, w + 32'd1, w ^ 32'hA5A5A5A5};
    endfunction

    // Engine stand-in: 3-cycle latency, ready toggles every cycle when free.
    logic       gate, e_busy;
    int         e_cnt;
    logic [127:0] e_res;
    assign eng_ready = gate && !e_busy;
    always @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0; e_busy <= 1'b0; e_cnt <= 0;
            eng_out_valid <= 1'b0; eng_out <= '0; e_res <= '0;
        end else begin
            gate <= ~gate;
            eng_out_valid <= 1'b0;
            if (eng_valid && eng_ready) begin
                e_busy <= 1'b1;
                e_cnt  <= 3;
                e_res  <= ef(eng_key, eng_klen, eng_block);
            end else if (e_busy) begin
                if (e_cnt == 1) begin
                    e_busy <= 1'b0;
                    eng_out_valid <= 1'b1;
                    eng_out <= e_res;
                end
                e_cnt <= e_cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            summary();
        end
    end

    // Monitor: compare every result pulse against the queue head (R11 order).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid) begin
            got++;
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, "/R11 extra"}, {128'b0, out_data}, '0);
            end else begin
                logic [127:0] e;
                e = exp_q.pop_front();
                check(out_data == e, cur_req, {128'b0, out_data}, {128'b0, e});
            end
        end
    end

    task automatic send(input logic [127:0] d, input bit last);
        in_data = d; in_last = last; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic configure_start(input logic [2:0] md, input logic [1:0] kl,
                                   input logic [255:0] k, input logic [127:0] iv0);
        @(negedge clk);
        cfg_mode = md; cfg_klen = kl; cfg_key = k; cfg_iv = iv0; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: start sets busy and clears done and tag_valid
        check(busy && !done && !tag_valid, "R9 start",
              {253'b0, busy, done, tag_valid}, 256'h4);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_simple(input logic [2:0] md, input logic [1:0] kl,
                              input logic [255:0] k, input logic [127:0] iv0,
                              input int n, input logic [127:0] seed,
                              input string req, input bit poke);
        logic [255:0] km;
        logic [127:0] ch, b;
        km = kmask(k, kl);
        ch = iv0;
        for (int i = 0; i < n; i++) begin
            b = mkblk(seed, i);
            case (md)
                3'd1: ch = ef(km, kl, b ^ ch);
                3'd2: begin exp_q.push_back(b ^ ef(km, kl, ch)); ch[31:0] = ch[31:0] + 32'd1; end
                3'd3: begin ch = ef(km, kl, ch); exp_q.push_back(b ^ ch); end
                default: exp_q.push_back(ef(km, kl, b));
            endcase
        end
        cur_req = req;
        got = 0;
        configure_start(md, kl, k, iv0);
        for (int i = 0; i < n; i++) begin
            send(mkblk(seed, i), i == n - 1);
            if (poke && i == 0) begin
                // R10: reconfigure attempt while busy must not take effect
                cfg_mode = 3'd2; cfg_klen = 2'd2; cfg_key = ~k; cfg_iv = ~iv0;
                cfg_load = 1'b1;
                @(negedge clk);
                cfg_load = 1'b0;
            end
        end
        wait_done();
        check(done && !busy, {req, "/R9 done"}, {254'b0, done, busy}, 256'h2);
        check(got == ((md == 3'd1) ? 0 : n), {req, " count"}, 256'(got),
              256'((md == 3'd1) ? 0 : n));
        check(exp_q.size() == 0, {req, "/R11 drained"}, 256'(exp_q.size()), '0);
        if (md == 3'd1) begin
            check(tag_valid && tag_out == ch, "R3 tag", {127'b0, tag_valid, tag_out},
                  {127'b0, 1'b1, ch});
        end
        exp_q.delete();
    endtask

    task automatic run_ccm(input logic [1:0] kl, input logic [255:0] k,
                           input int n1, input int n2, input logic [127:0] ctr0);
        logic [255:0] km;
        logic [127:0] ch, ct, b;
        km = kmask(k, kl);
        ch = '0;
        for (int i = 0; i < n1; i++) ch = ef(km, kl, mkblk(128'h0B0, i) ^ ch);
        ct = ctr0;
        for (int i = 0; i < n2; i++) begin
            b = mkblk(128'hD47A, i);
            exp_q.push_back(b ^ ef(km, kl, ct));
            ct[31:0] = ct[31:0] + 32'd1;
        end
        cur_req = "R6";
        got = 0;
        configure_start(3'd4, kl, k, '0);
        for (int i = 0; i < n1; i++) send(mkblk(128'h0B0, i), i == n1 - 1);
        while (!tag_valid) @(negedge clk);
        // R6: tag ready after the authentication pass while still busy
        check(busy, "R6 busy at tag", {255'b0, busy}, 256'h1);
        check(tag_out == ch, "R6 tag", {128'b0, tag_out}, {128'b0, ch});
        check(got == 0, "R6 no output in pass 1", 256'(got), '0);
        send(ctr0, 1'b0);
        for (int i = 0; i < n2; i++) send(mkblk(128'hD47A, i), i == n2 - 1);
        wait_done();
        check(got == n2, "R6 count", 256'(got), 256'(n2));
        check(exp_q.size() == 0, "R6/R11 drained", 256'(exp_q.size()), '0);
        check(tag_valid && tag_out == ch, "R6 tag kept", {128'b0, tag_out}, {128'b0, ch});
        exp_q.delete();
    endtask

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        cfg_mode = '0; cfg_klen = '0; cfg_key = '0; cfg_iv = '0; in_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(!busy && !done && !tag_valid && !out_valid && !in_ready && !eng_valid,
              "R1 reset", {250'b0, busy, done, tag_valid, out_valid, in_ready, eng_valid}, '0);

        // R2 + R7: codebook, 128-bit key length with junk in upper key bits
        run_simple(3'd0, 2'd0, {128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555,
                   128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210}, '0, 3,
                   128'h1111, "R2/R7 k128", 1'b0);
        // R3 + R7: CBC-MAC with 192-bit key length
        run_simple(3'd1, 2'd1, {128'hFFFF_0000_FFFF_0000_1357_9BDF_2468_ACE0,
                   128'h0F0F_1E1E_2D2D_3C3C_4B4B_5A5A_6969_7878},
                   128'hA5A5_0000_1234_5678_9ABC_DEF0_0000_0042, 4,
                   128'h2222, "R3/R7 k192", 1'b0);
        // R4: counter across the 2^32 wrap, 256-bit key length
        run_simple(3'd2, 2'd2, {8{32'hC3A5_1F0E}},
                   128'h0102_0304_0506_0708_090A_0B0C_FFFF_FFFE, 4,
                   128'h3333, "R4/R7 wrap", 1'b0);
        // R5: output feedback
        run_simple(3'd3, 2'd3, {8{32'h7E57_AB12}},
                   128'h0055_AA00_1122_3344_5566_7788_99AA_BBCC, 3,
                   128'h4444, "R5", 1'b0);
        // R10: reconfiguration while busy is ignored (codebook run)
        run_simple(3'd0, 2'd2, {4{64'h0DDC_0FFE_E15B_ADF0}}, '0, 3,
                   128'h5555, "R10", 1'b1);
        // R2: reserved mode code 6 behaves as codebook
        run_simple(3'd6, 2'd0, {8{32'h600D_F00D}}, '0, 2, 128'h6666, "R2 code6", 1'b0);
        // R6: two-pass CCM with counter seed wrapping
        run_ccm(2'd1, {8{32'h2B7E_1516}}, 3, 3, 128'hAB00_0000_0000_0000_0000_0001_FFFF_FFFF);
        // R4: counter single block after CCM
        run_simple(3'd2, 2'd0, {8{32'h1}}, 128'h5, 1, 128'h7777, "R4 single", 1'b0);

        summary();
    end
endmodule